// File: doc/BRIEF.md
# March C- Memory Test Sequencer

This block runs the six-element March C- test over a small single-port SRAM of two blocks, each with four columns of four rows (32 one-bit cells by default). A one-cycle `start` pulse launches the run. The sequencer first clears every cell. It then performs four read-then-write sweeps, two ascending and two descending. A final ascending read-only sweep closes the run. Every read result is compared with the value the algorithm expects, and one report cycle is produced per read.

The cell address is laid out as {block, column, row}. Stepping this address by one therefore walks the array one column at a time. Consecutive accesses stay in the same column, and within a block they also use the same I/O circuit. This is the access pattern that sensitises write-driver and precharge faults, which only show up after a write to a neighbouring cell. Each read report carries the addresses visited just before and just after it, in the current sweep's order. Diagnosis logic downstream can use these to separate dynamic faults from static ones.

The memory is driven through a plain synchronous port: address, write enable, write data and read data, with read data returned one cycle after the read command.

Top module: `march_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `busy`, `done`, `mem_we`, `rd_valid` and `rd_fail` are all 0.
- R2: After `start` is sampled, the first 32 cycles each write all-zero data, to addresses 0, 1, 2, … 31 in that order.
- R3: Cell address = {block, column, row}. Ascending order counts the address up from 0 to 31 and descending counts it down from 31 to 0. The read sweeps run ascending, ascending, descending, descending, ascending.
- R4: The five read sweeps expect 0, 1, 0, 1, 0 in turn. After each read in the first four sweeps, the sequencer writes the complement of the expected value to the same cell. The last sweep only reads.
- R5: `rd_idx` numbers the reads 0 to 4 in sweep order, and each sweep reports exactly 32 reads.
- R6: Read data is taken one cycle after the read command. `rd_valid` is high for that single compare cycle, and `rd_fail` is high with it exactly when the data differs from `rd_exp`, with `rd_addr` naming the cell.
- R7: With each read, `prev_addr`/`next_addr` give the cells visited immediately before and after it in the current sweep's direction. `prev_ok`/`next_ok` are 0 at the ends of the sweep.
- R8: `done` is high for exactly one cycle, 353 cycles after the edge that samples `start`, and `busy` falls in that same cycle.
- R9: A `start` pulse during a run has no effect: the run's timing, read reports and single `done` are unchanged.
- R10: A cell stuck at 0 fails reads 1 and 3 only. A cell stuck at 1 fails reads 0, 2 and 4. A cell that cannot rise fails reads 1 and 3. A cell that cannot fall, holding 0 before the run, fails reads 2 and 4. Every failure names that cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch a run when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| mem_addr | output | AW | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle latency |
| rd_valid | output | 1 | Read report valid (compare cycle) |
| rd_idx | output | 3 | Read number 0..4 |
| rd_addr | output | AW | Address of the reported read |
| rd_exp | output | DW | Expected read value |
| rd_fail | output | 1 | Read mismatch |
| prev_addr | output | AW | Cell visited before this read |
| prev_ok | output | 1 | prev_addr is present |
| next_addr | output | AW | Cell visited after this read |
| next_ok | output | 1 | next_addr is present |

## Verification
From the ports, the hardest case to reach is a read that fails only because of what earlier sweeps wrote to that one cell. The fault signatures of R10 are not visible unless the memory itself misbehaves. The bench therefore holds a behavioural memory that can be armed with stuck-at or one-directional transition faults at a chosen cell. A table of fault cases is then walked, and the set of failing read numbers and the failing address are collected for each case. One case also pulses `start` in the middle of a run, and a separate run is cut short by reset.

// File: rtl/march_seq.sv
`timescale 1ns/1ps
module march_seq #(
  parameter int BLK_W = 1,
  parameter int COL_W = 2,
  parameter int ROW_W = 2,
  parameter int DW    = 1,
  localparam int AW   = BLK_W + COL_W + ROW_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          rd_valid,
  output logic [2:0]    rd_idx,
  output logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_exp,
  output logic          rd_fail,
  output logic [AW-1:0] prev_addr,
  output logic          prev_ok,
  output logic [AW-1:0] next_addr,
  output logic          next_ok
);
  localparam logic [AW-1:0] A_MAX = '1;
  localparam logic [AW-1:0] A_ONE = AW'(1);

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_RD, S_CW} st_t;

  st_t          st;
  logic [2:0]   elem;
  logic [AW-1:0] addr;
  logic         done_q;

  wire desc    = (elem == 3'd3) || (elem == 3'd4);
  wire exp_bit = (elem == 3'd2) || (elem == 3'd4);
  wire at_last = desc ? (addr == '0) : (addr == A_MAX);
  wire [AW-1:0] up_a = addr + A_ONE;
  wire [AW-1:0] dn_a = addr - A_ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      elem   <= 3'd0;
      addr   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st   <= S_FILL;
          elem <= 3'd0;
          addr <= '0;
        end
        S_FILL: if (addr == A_MAX) begin
          st   <= S_RD;
          elem <= 3'd1;
          addr <= '0;
        end else begin
          addr <= up_a;
        end
        S_RD: st <= S_CW;
        S_CW: begin
          if (at_last) begin
            if (elem == 3'd5) begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              elem <= elem + 3'd1;
              addr <= ((elem == 3'd2) || (elem == 3'd3)) ? A_MAX : '0;
              st   <= S_RD;
            end
          end else begin
            addr <= desc ? dn_a : up_a;
            st   <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign mem_addr  = addr;
  assign mem_we    = (st == S_FILL) || ((st == S_CW) && (elem != 3'd5));
  assign mem_wdata = (st == S_FILL) ? '0 : {DW{~exp_bit}};

  assign rd_valid  = (st == S_CW);
  assign rd_idx    = elem - 3'd1;
  assign rd_addr   = addr;
  assign rd_exp    = {DW{exp_bit}};
  assign rd_fail   = rd_valid && (mem_rdata != rd_exp);

  assign prev_addr = desc ? up_a : dn_a;
  assign prev_ok   = desc ? (addr != A_MAX) : (addr != '0);
  assign next_addr = desc ? dn_a : up_a;
  assign next_ok   = desc ? (addr != '0) : (addr != A_MAX);
endmodule

module march_seq_chk #(
  parameter int AW = 5,
  parameter int DW = 1
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          mem_we,
  input logic [DW-1:0] mem_wdata,
  input logic          rd_valid,
  input logic [2:0]    rd_idx,
  input logic [AW-1:0] rd_addr,
  input logic          rd_fail,
  input logic [AW-1:0] prev_addr,
  input logic          prev_ok
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done);
  // R6
  fail_qual_chk: assert property (@(posedge clk) disable iff (rst) rd_fail |-> rd_valid);
  // R6
  read_gap_chk: assert property (@(posedge clk) disable iff (rst) rd_valid |=> !rd_valid);
  // R5
  idx_range_chk: assert property (@(posedge clk) disable iff (rst) rd_valid |-> (rd_idx <= 3'd4));
  // R7
  prev_diff_chk: assert property (@(posedge clk) disable iff (rst) (rd_valid && prev_ok) |-> (prev_addr != rd_addr));
  // R2
  fill_zero_chk: assert property (@(posedge clk) disable iff (rst) (mem_we && !rd_valid) |-> (mem_wdata == '0));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> (!mem_we && !rd_valid));
endmodule

bind march_seq march_seq_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/test_march_seq.sv
`timescale 1ns/1ps
module test_march_seq;
  localparam int AW = 5;
  localparam int NC = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic busy, done, mem_we, rd_valid, rd_fail, prev_ok, next_ok;
  logic [AW-1:0] mem_addr, rd_addr, prev_addr, next_addr;
  logic [0:0] mem_wdata, rd_exp;
  logic [0:0] mem_rdata = 1'b0;
  logic [2:0] rd_idx;

  always #2.5 clk = ~clk;

  march_seq i_march_seq (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rd_valid(rd_valid), .rd_idx(rd_idx), .rd_addr(rd_addr), .rd_exp(rd_exp), .rd_fail(rd_fail),
    .prev_addr(prev_addr), .prev_ok(prev_ok), .next_addr(next_addr), .next_ok(next_ok)
  );

  // behavioural memory with one injectable fault
  logic mem [NC];
  logic [2:0] fty = 3'd0;
  logic [AW-1:0] fad = '0;
  logic init_req = 1'b0;

  function automatic logic wval(logic old, logic nw, logic [AW-1:0] a);
    if (a != fad) return nw;
    case (fty)
      3'd1: return 1'b0;
      3'd2: return 1'b1;
      3'd3: return (!old && nw) ? 1'b0 : nw;
      3'd4: return (old && !nw) ? 1'b1 : nw;
      default: return nw;
    endcase
  endfunction

  always @(posedge clk) begin
    if (init_req) begin
      for (int i = 0; i < NC; i++) mem[i] <= !(fty == 3'd4 && AW'(i) == fad);
    end else if (mem_we) begin
      mem[mem_addr] <= wval(mem[mem_addr], mem_wdata[0], mem_addr);
    end else begin
      mem_rdata[0] <= mem[mem_addr];
    end
  end

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // {fault type, fault cell, expected failing-read mask (bit i = read i)}
  localparam logic [12:0] VEC [5] = '{
    {3'd0, 5'd0,  5'b00000},
    {3'd1, 5'd13, 5'b01010},
    {3'd2, 5'd31, 5'b10101},
    {3'd3, 5'd4,  5'b01010},
    {3'd4, 5'd0,  5'b10100}
  };

  task automatic run_case(logic [2:0] t, logic [AW-1:0] a, logic [4:0] mask, bit extra_start);
    int cnt = 0, nreads = 0, fills = 0;
    int seq_err = 0, nbr_err = 0, exp_err = 0, fill_err = 0, addr_err = 0;
    logic [4:0] fmask = '0;
    @(negedge clk);
    fty = t; fad = a; init_req = 1'b1;
    @(negedge clk);
    init_req = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 1;
    while (!done && cnt < 1000) begin
      if (extra_start && cnt == 100) start = 1'b1;
      else start = 1'b0;
      if (mem_we && !rd_valid) begin
        if (mem_addr != AW'(fills) || mem_wdata != 1'b0) fill_err++;
        fills++;
      end
      if (rd_valid) begin
        int p = nreads % NC;
        int ix = nreads / NC;
        bit asc = (ix != 2) && (ix != 3);
        int ea = asc ? p : NC - 1 - p;
        if (int'(rd_idx) != ix || int'(rd_addr) != ea) seq_err++;
        if (rd_exp[0] != ((ix == 1) || (ix == 3))) exp_err++;
        if (asc) begin
          if (prev_ok != (ea != 0) || (ea != 0 && int'(prev_addr) != ea - 1)) nbr_err++;
          if (next_ok != (ea != NC - 1) || (ea != NC - 1 && int'(next_addr) != ea + 1)) nbr_err++;
        end else begin
          if (prev_ok != (ea != NC - 1) || (ea != NC - 1 && int'(prev_addr) != ea + 1)) nbr_err++;
          if (next_ok != (ea != 0) || (ea != 0 && int'(next_addr) != ea - 1)) nbr_err++;
        end
        if (rd_fail) begin
          fmask[rd_idx] = 1'b1;
          if (rd_addr != a) addr_err++;
        end
        nreads++;
      end
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    chk(cnt == 353, extra_start ? "R9 done timing with mid-run start" : "R8 done timing", cnt, 353);
    chk(!busy, "R8 busy low with done", busy, 0);
    chk(fills == 32 && fill_err == 0, "R2 fill writes", fill_err, 0);
    chk(nreads == 160, "R5 read count", nreads, 160);
    chk(seq_err == 0, "R3 R5 visit order and index", seq_err, 0);
    chk(exp_err == 0, "R4 expected values", exp_err, 0);
    chk(nbr_err == 0, "R7 neighbour addresses", nbr_err, 0);
    chk(fmask == mask, t == 0 ? "R6 clean run" : "R10 fault signature", fmask, mask);
    chk(addr_err == 0, "R6 fail address", addr_err, 0);
    @(negedge clk);
    chk(!done && !busy, "R8 done single cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_we && !rd_valid && !rd_fail, "R1 in reset", busy, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !mem_we && !rd_valid, "R1 after reset", busy, 0);

    for (int v = 0; v < 5; v++)
      run_case(VEC[v][12:10], VEC[v][9:5], VEC[v][4:0], v == 2);

    // reset in mid-run
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (70) @(negedge clk);
    chk(busy, "R1 running before reset", busy, 1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !mem_we && !rd_valid, "R1 mid-run reset", busy, 0);
    run_case(3'd1, 5'd20, 5'b01010, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule